// File: doc/BRIEF.md
# Uncached Physical Address Filter

This stage sits directly after address translation. It looks at the translated physical address and decides whether the access may go through the caches. An address whose top implemented bit is set belongs to uncached space. Such a request leaves the stage marked both uncacheable and strictly ordered, and a band of platform-select bits below the top bit is cleared from the address it carries onward.

Two kinds of uncached request are trapped instead of passed through. The first is any address that lands in the internal-register window, which has no backing here. The second is an instruction fetch that targets uncached I/O, because fetching from a device register could destroy data that is cleared when read. All results are computed combinationally and, in the default configuration, captured in one output register stage. Each result is presented together with a valid flag one clock after its request.

Top module: `upa_filter`

## Requirements
- R1: When address bit 43 is 0, the output address equals the input address, out_uncacheable and out_strict are 0 and out_fault is 2'b00 (none).
- R2: When bit 43 is 1 and bits 42:40 equal 3'b111 (register window), out_fault is 2'b01, the address is passed unchanged and both flags are 0.
- R3: When bit 43 is 1 outside the register window, bits 42:35 of the output address are 0 and every other bit equals the input.
- R4: An uncached request outside the register window sets out_uncacheable and out_strict together.
- R5: An uncached request outside the register window reports out_fault 2'b10 when in_fetch is 1 and 2'b00 when in_fetch is 0.
- R6: A register-window address reports 2'b01 even when in_fetch is 1 (the window fault takes priority over the fetch fault).
- R7: out_valid equals in_valid delayed by one clock, and it is 0 while rst_n is low.
- R8: In the cycle after in_valid is 0, out_fault is 2'b00 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A translated request is present |
| in_paddr | input | 44 | Translated physical address |
| in_fetch | input | 1 | Request is an instruction fetch |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_paddr | output | 44 | Adjusted physical address |
| out_uncacheable | output | 1 | Request must bypass the caches |
| out_strict | output | 1 | Request must stay strictly ordered |
| out_fault | output | 2 | 00 none, 01 register window, 10 uncached fetch |

## Verification
Every result (address, both flags, fault code and valid) is due exactly one clock after the request is presented. The bench drives each request on a falling edge. The request is captured on the next rising edge, and the bench compares all outputs on the falling edge after that, just before it drives the next request. The sweep covers all 512 values of bits 43:35 with both fetch settings. The low bits are pseudo-random, so the window boundary, the cleared band and the bits around it are all exercised. Idle cycles are inserted between requests so that the output state after a cycle with no request is checked as well.

// File: rtl/upa_pkg.sv
package upa_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_REGWIN  = 2'b01,
    FLT_IOFETCH = 2'b10
  } upa_fault_e;
endpackage

// File: rtl/upa_classify.sv
module upa_classify
  import upa_pkg::*;
#(
  parameter int PA_W    = 44,
  parameter int UNC_BIT = 43,
  parameter int WIN_HI  = 42,
  parameter int WIN_LO  = 40,
  parameter int WIN_VAL = 7
) (
  input  logic [PA_W-1:0] paddr,
  input  logic            fetch,
  output logic            uncached,
  output logic            in_window,
  output upa_fault_e      fault
);
  localparam int WIN_W = WIN_HI - WIN_LO + 1;
  localparam logic [WIN_W-1:0] WIN_KEY = WIN_W'(WIN_VAL);

  always_comb begin
    uncached  = paddr[UNC_BIT];
    in_window = uncached && (paddr[WIN_HI:WIN_LO] == WIN_KEY);
    // window fault wins over the fetch fault (R6)
    if (in_window)            fault = FLT_REGWIN;
    else if (uncached && fetch) fault = FLT_IOFETCH;
    else                      fault = FLT_NONE;
  end
endmodule

// File: rtl/upa_strip.sv
module upa_strip #(
  parameter int PA_W   = 44,
  parameter int CLR_HI = 42,
  parameter int CLR_LO = 35
) (
  input  logic [PA_W-1:0] paddr_in,
  input  logic            strip_en,
  output logic [PA_W-1:0] paddr_out
);
  localparam logic [PA_W-1:0] CLR_MASK =
    (PA_W'(1) << (CLR_HI + 1)) - (PA_W'(1) << CLR_LO);

  always_comb begin
    paddr_out = strip_en ? (paddr_in & ~CLR_MASK) : paddr_in;
  end
endmodule

// File: rtl/upa_filter.sv
module upa_filter
  import upa_pkg::*;
#(
  parameter int PA_W         = 44,
  parameter int UNC_BIT      = 43,
  parameter int CLR_HI       = 42,
  parameter int CLR_LO       = 35,
  parameter int WIN_HI       = 42,
  parameter int WIN_LO       = 40,
  parameter int WIN_VAL      = 7,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_fetch,
  output logic            out_valid,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_uncacheable,
  output logic            out_strict,
  output logic [1:0]      out_fault
);
  logic            c_uncached;
  logic            c_window;
  upa_fault_e      c_fault;
  logic [PA_W-1:0] c_paddr;
  logic            c_flag;

  upa_classify #(
    .PA_W(PA_W), .UNC_BIT(UNC_BIT), .WIN_HI(WIN_HI), .WIN_LO(WIN_LO), .WIN_VAL(WIN_VAL)
  ) u_classify (
    .paddr(in_paddr), .fetch(in_fetch),
    .uncached(c_uncached), .in_window(c_window), .fault(c_fault)
  );

  assign c_flag = c_uncached && !c_window;

  upa_strip #(.PA_W(PA_W), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO)) u_strip (
    .paddr_in(in_paddr), .strip_en(c_flag), .paddr_out(c_paddr)
  );

  generate
    if (REGISTER_OUT) begin : g_reg
      logic            valid_q, valid_d;
      logic [PA_W-1:0] paddr_q, paddr_d;
      logic            unc_q, unc_d;
      logic [1:0]      fault_q, fault_d;

      always_comb begin
        valid_d = in_valid;
        paddr_d = paddr_q;
        unc_d   = 1'b0;
        fault_d = FLT_NONE;
        if (in_valid) begin
          paddr_d = c_paddr;
          unc_d   = c_flag;
          fault_d = c_fault;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          paddr_q <= '0;
          unc_q   <= 1'b0;
          fault_q <= FLT_NONE;
        end else begin
          valid_q <= valid_d;
          paddr_q <= paddr_d;
          unc_q   <= unc_d;
          fault_q <= fault_d;
        end
      end

      assign out_valid       = valid_q;
      assign out_paddr       = paddr_q;
      assign out_uncacheable = unc_q;
      assign out_strict      = unc_q;
      assign out_fault       = fault_q;

      a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

      a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_paddr[UNC_BIT]) |=>
          (out_paddr == $past(in_paddr) && !out_uncacheable && out_fault == 2'b00));

      a_r2_window_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_paddr[UNC_BIT] && in_paddr[WIN_HI:WIN_LO] == (WIN_HI-WIN_LO+1)'(WIN_VAL))
          |=> (out_fault == 2'b01 && !out_uncacheable && out_paddr == $past(in_paddr)));

      a_r5_fetch_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fetch && in_paddr[UNC_BIT]
          && in_paddr[WIN_HI:WIN_LO] != (WIN_HI-WIN_LO+1)'(WIN_VAL))
          |=> (out_fault == 2'b10 && out_uncacheable && out_strict));

      a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_fault == 2'b00 && !out_uncacheable && !out_strict));
    end else begin : g_comb
      assign out_valid       = in_valid;
      assign out_paddr       = c_paddr;
      assign out_uncacheable = in_valid && c_flag;
      assign out_strict      = in_valid && c_flag;
      assign out_fault       = in_valid ? c_fault : FLT_NONE;
    end
  endgenerate
endmodule

// File: tb/upa_filter_tb.sv
module upa_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [43:0] in_paddr;
  logic        in_fetch;
  logic        out_valid;
  logic [43:0] out_paddr;
  logic        out_uncacheable;
  logic        out_strict;
  logic [1:0]  out_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  upa_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_paddr(in_paddr),
    .in_fetch(in_fetch), .out_valid(out_valid), .out_paddr(out_paddr),
    .out_uncacheable(out_uncacheable), .out_strict(out_strict), .out_fault(out_fault)
  );

  bit          pend = 0;
  logic        e_valid;
  logic [43:0] e_paddr;
  logic        e_unc;
  logic [1:0]  e_fault;
  logic        e_addr_chk;
  string       e_tag;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [43:0] a, input logic f);
    logic unc, win;
    unc = a[43];
    win = unc && (a[42:40] == 3'b111);
    e_valid = v;
    e_addr_chk = v;
    e_paddr = a;
    e_unc = 1'b0;
    e_fault = 2'b00;
    e_tag = "R8";
    if (v) begin
      if (!unc) begin
        e_tag = "R1";
      end else if (win) begin
        e_fault = 2'b01;
        e_tag = f ? "R6" : "R2";
      end else begin
        e_paddr = a & ~(44'hFF << 35);
        e_unc = 1'b1;
        e_fault = f ? 2'b10 : 2'b00;
        e_tag = f ? "R5" : "R3/R4";
      end
    end
  endtask

  task automatic step(input logic v, input logic [43:0] a, input logic f);
    @(negedge clk);
    if (pend) begin
      check("R7 out_valid", 64'(out_valid), 64'(e_valid));
      if (e_addr_chk) check({e_tag, " out_paddr"}, 64'(out_paddr), 64'(e_paddr));
      check({e_tag, " out_uncacheable"}, 64'(out_uncacheable), 64'(e_unc));
      check({e_tag, " out_strict"}, 64'(out_strict), 64'(e_unc));
      check({e_tag, " out_fault"}, 64'(out_fault), 64'(e_fault));
    end
    in_valid = v;
    in_paddr = a;
    in_fetch = f;
    model(v, a, f);
    pend = 1;
  endtask

  initial begin
    logic [34:0] lfsr;
    lfsr = 35'h1_2345_6789;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_paddr = '0;
    in_fetch = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", 64'(out_valid), 64'd0);
    check("R8 reset out_fault", 64'(out_fault), 64'd0);
    check("R8 reset out_uncacheable", 64'(out_uncacheable), 64'd0);
    rst_n = 1'b1;
    for (int hi = 0; hi < 512; hi++) begin
      for (int f = 0; f < 2; f++) begin
        lfsr = {lfsr[33:0], lfsr[34] ^ lfsr[32]};
        step(1'b1, {hi[8:0], lfsr}, f[0]);
      end
      if (hi % 37 == 0) step(1'b0, 44'hFFF_FFFF_FFFF, 1'b1);
    end
    step(1'b1, 44'h8FF_FFFF_FFFF, 1'b1);
    step(1'b1, 44'hE00_0000_0000, 1'b1);
    step(1'b1, 44'h7FF_FFFF_FFFF, 1'b1);
    step(1'b0, 44'h0, 1'b0);
    step(1'b0, 44'h0, 1'b0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule